// File: doc/BRIEF.md
# Self-Supplied Controller Supply and Fault Sequencer

This block decides, cycle by cycle, what a self-supplied switching controller does with its supply and its output pulses. It takes digitized supply comparator flags (at or above 12 V, below 10 V, below 5.3 V, below 4 V), an overload flag that is high while the feedback loop demands maximum peak current, and an overvoltage comparator result with the strobe that marks when it was sampled. It drives the enable of the high-voltage start-up current source, the enable of the switching pulses, a low-power standby indication, and a soft-start code that scales the peak-current setpoint.

During normal operation the supply capacitor is kept between 10 V and 12 V by switching the current source on and off with hysteresis while pulsing continues. The time the supply takes to fall from 12 V to 10 V serves as the overload timeout. A persistent overload stops everything until the supply has dropped to 5.3 V, and then a fresh start is attempted. An overvoltage seen at the strobe latches switching off for good. Only a collapse of the supply below 4 V clears that latch. Each time pulsing starts, the soft-start code begins again from zero.

Top module: `supply_fault_seq`

## Requirements
- R1: After reset the current source is enabled and pulsing, standby and the soft-start code are all zero. This holds until the 12 V flag is seen.
- R2: When the 12 V flag is seen while starting, the next cycle has the source off and pulsing on. Pulsing never begins in a cycle unless the 12 V flag was high in the cycle before.
- R3: While pulsing, the 10 V flag turns the source on and the 12 V flag turns it off, each one cycle later. The pulse enable stays high in both phases.
- R4: An overload while the source is on (the supply is charging) has no effect.
- R5: An overload seen while the source is off starts a watch. If the overload is still present when the 10 V flag arrives, the next cycle has pulsing off, the source off and standby high.
- R6: If the overload clears during the watch, pulsing continues. A later 10 V flag turns the source on as in R3.
- R7: In standby the source stays off, even after the overload is gone, until the 5.3 V flag. The source then turns on without pulses, and pulsing resumes at the next 12 V flag.
- R8: A high overvoltage flag with its strobe high latches the block. From the next cycle pulsing is off and standby is low. The overvoltage flag without the strobe is ignored. Overvoltage wins over a simultaneous overload.
- R9: While latched, the source still follows the 10 V / 12 V hysteresis and the 5.3 V flag does not clear the latch. Only the 4 V flag returns the block to start-up.
- R10: The soft-start code is zero whenever pulses are disabled. Once pulsing starts it rises by one every SS_DIV cycles and saturates at all ones (63 with the default 6 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_hi | input | 1 | Supply at or above the 12 V threshold |
| vcc_lo | input | 1 | Supply below the 10 V threshold |
| vcc_rearm | input | 1 | Supply below the 5.3 V restart threshold |
| vcc_clr | input | 1 | Supply below the 4 V collapse threshold |
| ovl | input | 1 | Overload: feedback at its maximum |
| ovp | input | 1 | Overvoltage comparator result |
| ovp_strobe | input | 1 | Marks the cycle in which ovp is valid |
| src_en | output | 1 | Start-up current source enable |
| pulse_en | output | 1 | Switching pulse enable |
| standby | output | 1 | Low-power standby after an overload timeout |
| ss_code | output | SS_BITS | Soft-start scale for the peak-current setpoint |

## Verification
The sequencing is tried with a supply that ramps up from zero and then swings repeatedly between its two regulation flags. On top of that come an overload asserted during charging, an overload that ends during discharge, and one that lasts until 10 V. Together these separate an overload that is ignored, one that is forgiven and one that times out. Overvoltage is applied without its strobe, with its strobe alongside an overload, and then followed by supply dips to 5.3 V and to 4 V. This shows that only the deeper collapse clears the latch. The soft-start code is checked at a mid-ramp point, at saturation and after a shutdown.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

    typedef enum logic [2:0] {
        ST_START   = 3'd0,
        ST_RUN     = 3'd1,
        ST_WATCH   = 3'd2,
        ST_STANDBY = 3'd3,
        ST_LATCH   = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       src;
    } seq_regs_t;

endpackage

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
    import supply_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_hi,
    input  logic       vcc_lo,
    input  logic       vcc_rearm,
    input  logic       vcc_clr,
    input  logic       ovl,
    input  logic       ovp,
    input  logic       ovp_strobe,
    output seq_state_e state_o,
    output logic       src_en
);

    seq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_START: begin
                regs_d.src = !vcc_hi;
                if (vcc_hi) regs_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (vcc_hi)      regs_d.src = 1'b0;
                else if (vcc_lo) regs_d.src = 1'b1;
                // watch only while discharging from the upper threshold
                if (!regs_q.src && ovl) regs_d.state = ST_WATCH;
            end
            ST_WATCH: begin
                if (!ovl) begin
                    regs_d.state = ST_RUN;
                    if (vcc_lo) regs_d.src = 1'b1;
                end else if (vcc_lo) begin
                    regs_d.state = ST_STANDBY;
                    regs_d.src   = 1'b0;
                end
            end
            ST_STANDBY: begin
                regs_d.src = vcc_rearm;
                if (vcc_rearm) regs_d.state = ST_START;
            end
            ST_LATCH: begin
                if (vcc_hi)      regs_d.src = 1'b0;
                else if (vcc_lo) regs_d.src = 1'b1;
                if (vcc_clr) begin
                    regs_d.state = ST_START;
                    regs_d.src   = 1'b1;
                end
            end
            default: begin
                regs_d.state = ST_START;
                regs_d.src   = 1'b1;
            end
        endcase
        // overvoltage outranks every other transition
        if (ovp_strobe && ovp && regs_q.state != ST_LATCH)
            regs_d.state = ST_LATCH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_START;
            regs_q.src   <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign src_en  = regs_q.src;

    p_src_off_at_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_hi && !vcc_rearm) |=> !src_en);

    p_src_on_at_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_RUN && vcc_lo && !vcc_hi && !(ovp && ovp_strobe)) |=> src_en);

    p_standby_src_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_STANDBY && !vcc_rearm) |=> !src_en);

    p_ovp_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp && ovp_strobe) |=> (regs_q.state == ST_LATCH || $past(regs_q.state) == ST_LATCH));

    p_latch_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_LATCH && !vcc_clr) |=> regs_q.state == ST_LATCH);

endmodule

// File: rtl/supply_ss_ramp.sv
module supply_ss_ramp #(
    parameter int SS_BITS = 6,
    parameter int SS_DIV  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    output logic [SS_BITS-1:0] code
);

    localparam int PRE_W = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
    localparam logic [PRE_W-1:0]   PRE_LAST = PRE_W'(SS_DIV - 1);
    localparam logic [SS_BITS-1:0] FULL     = '1;

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [SS_BITS-1:0] code;
    } ramp_regs_t;

    ramp_regs_t ramp_d, ramp_q;

    always_comb begin
        ramp_d = ramp_q;
        if (!run) begin
            ramp_d = '0;
        end else if (ramp_q.pre == PRE_LAST) begin
            ramp_d.pre = '0;
            if (ramp_q.code != FULL) ramp_d.code = ramp_q.code + 1'b1;
        end else begin
            ramp_d.pre = ramp_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ramp_q <= '0;
        else        ramp_q <= ramp_d;
    end

    assign code = ramp_q.code;

    p_ss_zero_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> code == '0);

    p_ss_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (code == $past(code) || code == $past(code) + 1'b1));

endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq
    import supply_seq_pkg::*;
#(
    parameter int SS_BITS = 6,
    parameter int SS_DIV  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vcc_hi,
    input  logic               vcc_lo,
    input  logic               vcc_rearm,
    input  logic               vcc_clr,
    input  logic               ovl,
    input  logic               ovp,
    input  logic               ovp_strobe,
    output logic               src_en,
    output logic               pulse_en,
    output logic               standby,
    output logic [SS_BITS-1:0] ss_code
);

    seq_state_e state;

    supply_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcc_hi     (vcc_hi),
        .vcc_lo     (vcc_lo),
        .vcc_rearm  (vcc_rearm),
        .vcc_clr    (vcc_clr),
        .ovl        (ovl),
        .ovp        (ovp),
        .ovp_strobe (ovp_strobe),
        .state_o    (state),
        .src_en     (src_en)
    );

    assign pulse_en = (state == ST_RUN) || (state == ST_WATCH);
    assign standby  = (state == ST_STANDBY);

    supply_ss_ramp #(
        .SS_BITS (SS_BITS),
        .SS_DIV  (SS_DIV)
    ) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pulse_en),
        .code  (ss_code)
    );

    p_pulse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_en) |-> $past(vcc_hi));

    p_standby_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!pulse_en && !src_en));

endmodule

// File: tb/tb_supply_fault_seq.sv
module tb_supply_fault_seq;

    localparam int SS_BITS = 6;
    localparam int SS_DIV  = 4;
    localparam int NVEC    = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_hi = 0, vcc_lo = 1, vcc_rearm = 1, vcc_clr = 1;
    logic ovl = 0, ovp = 0, ovp_strobe = 0;
    logic src_en, pulse_en, standby;
    logic [SS_BITS-1:0] ss_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    supply_fault_seq #(.SS_BITS(SS_BITS), .SS_DIV(SS_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .vcc_hi(vcc_hi), .vcc_lo(vcc_lo),
        .vcc_rearm(vcc_rearm), .vcc_clr(vcc_clr), .ovl(ovl), .ovp(ovp),
        .ovp_strobe(ovp_strobe), .src_en(src_en), .pulse_en(pulse_en),
        .standby(standby), .ss_code(ss_code)
    );

    // {hi, lo, rearm, clr, ovl, ovp, strobe, exp_src, exp_pulse, exp_stby, req[3:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {7'b0111000, 3'b100, 4'd1},  // R1 collapsed supply, starting
        {7'b0100000, 3'b100, 4'd1},  // R1
        {7'b0000000, 3'b100, 4'd1},  // R1 between thresholds
        {7'b1000000, 3'b010, 4'd2},  // R2 12 V reached
        {7'b0000000, 3'b010, 4'd3},  // R3 discharging
        {7'b0100000, 3'b110, 4'd3},  // R3 10 V: source on
        {7'b0000100, 3'b110, 4'd4},  // R4 overload while charging
        {7'b1000100, 3'b010, 4'd4},  // R4 12 V with overload
        {7'b0000100, 3'b010, 4'd5},  // R5 watch begins
        {7'b0000000, 3'b010, 4'd6},  // R6 overload gone
        {7'b0100000, 3'b110, 4'd6},  // R6 10 V normal
        {7'b1000000, 3'b010, 4'd3},  // R3
        {7'b0000100, 3'b010, 4'd5},  // R5 watch
        {7'b0100100, 3'b001, 4'd5},  // R5 timeout -> standby
        {7'b0100000, 3'b001, 4'd7},  // R7 holds without rearm
        {7'b0110000, 3'b100, 4'd7},  // R7 5.3 V restart
        {7'b0100000, 3'b100, 4'd7},  // R7
        {7'b1000000, 3'b010, 4'd7},  // R7 pulses resume
        {7'b0000010, 3'b010, 4'd8},  // R8 no strobe: ignored
        {7'b0000111, 3'b000, 4'd8},  // R8 strobe + overload -> latch
        {7'b0100000, 3'b100, 4'd9},  // R9 regulation in latch
        {7'b0000000, 3'b100, 4'd9},  // R9
        {7'b1000000, 3'b000, 4'd9},  // R9
        {7'b0110000, 3'b100, 4'd9},  // R9 5.3 V does not clear
        {7'b0111000, 3'b100, 4'd9},  // R9 4 V clears
        {7'b1000000, 3'b010, 4'd9}   // R9 restart after clear
    };

    task automatic set_in(input logic [6:0] v);
        {vcc_hi, vcc_lo, vcc_rearm, vcc_clr, ovl, ovp, ovp_strobe} = v;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [2:0] e);
        check(req, int'({src_en, pulse_en, standby}), int'(e));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_in(7'b0111000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check_outs("R1", 3'b100);
        check("R1", int'(ss_code), 0);

        for (int i = 0; i < NVEC; i++) begin
            set_in(VEC[i][13:7]);
            step();
            check_outs($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][6:4]);
        end

        // R10 soft-start ramp
        do_reset();
        set_in(7'b1000000);
        step();
        check("R10 start", int'(ss_code), 0);
        check_outs("R2", 3'b010);
        set_in(7'b0000000);
        repeat (4 * SS_DIV) step();
        check("R10 mid-ramp", int'(ss_code), 4);
        repeat (64 * SS_DIV) step();
        check("R10 saturate", int'(ss_code), 63);
        step();
        check("R10 stays full", int'(ss_code), 63);
        set_in(7'b0000011);
        step();
        set_in(7'b0000000);
        step();
        check("R10 zero after latch", int'(ss_code), 0);
        check_outs("R8", 3'b000);

        // R10 restart from standby ramps again from zero
        do_reset();
        set_in(7'b1000000); step();
        set_in(7'b0000100); step();
        set_in(7'b0100100); step();
        check_outs("R5", 3'b001);
        check("R10 standby", int'(ss_code), 0);
        set_in(7'b0110000); step();
        set_in(7'b1000000); step();
        set_in(7'b0000000);
        repeat (2 * SS_DIV) step();
        check("R10 restart ramp", int'(ss_code), 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule